// File: doc/BRIEF.md
# Floating-Point Fault Routing Control

This block holds the floating-point interface flags of a processor control register and uses them to decide what happens when a waiting-type floating-point instruction issues. A waiting instruction can meet one of three conditions. The floating-point context may belong to another task. The instruction may find an unmasked numeric exception pending. Or nothing may be outstanding. The block turns each case into one of these results: a device-not-available trap request, an internal numeric-error trap request, an external error-pin assertion, or no action.

Software reads and writes the control register through a simple port. A hardware task switch can also set the task-switched flag directly. The numeric-exception flag chooses how an unmasked floating-point fault is reported. When it is set, the fault is raised internally as a vectored trap. When it is clear, an external error line is driven towards an outside interrupt controller. The extension-type flag is fixed and always reads as set. Trap requests are registered and appear in the cycle after the waiting instruction. Each request carries its vector number.

Top module: `fpu_fault_ctl`

## Requirements
- R1: After synchronous reset, the register reads 0x00000010 and dna_trap, num_trap, ext_err are 0, with trap_vector 0.
- R2: Bit 4 (extension type) always reads 1, and writing 0 to it has no effect on the readback.
- R3: Every register bit other than 1, 3, 4 and 5 reads 0 whatever value is written.
- R4: Bit 1 (monitor coprocessor), bit 3 (task switched) and bit 5 (numeric exception) take the written value, which is visible on cr_rd_data in the cycle after the write edge.
- R5: A task_switch pulse sets bit 3. If a register write occurs in the same cycle, the pulse wins.
- R6: A waiting instruction that issues while bits 1 and 3 are both 1 raises dna_trap for one cycle in the next cycle, with trap_vector = 7.
- R7: A waiting instruction that issues while bit 1 or bit 3 is 0 raises no dna_trap.
- R8: A waiting instruction without a device-not-available condition, with fp_exc_pending = 1 and bit 5 = 1, raises num_trap for one cycle in the next cycle with trap_vector = 16 and leaves ext_err unchanged.
- R9: The same case with bit 5 = 0 raises no num_trap. Instead ext_err is driven to 1 from the next cycle and held until the cycle after fp_exc_pending falls.
- R10: When the device-not-available condition holds, a pending exception produces neither num_trap nor a new ext_err assertion for that instruction.
- R11: A waiting instruction with no pending exception and no device-not-available condition produces no trap and no ext_err.
- R12: trap requests are single-cycle pulses, only one of dna_trap and num_trap is ever high, and trap_vector is 0 when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_wr_en | input | 1 | Register write strobe |
| cr_wr_data | input | REG_W | Register write value |
| cr_rd_data | output | REG_W | Register readback |
| task_switch | input | 1 | Hardware task switch pulse; sets the task-switched flag |
| fp_wait_op | input | 1 | Pulse: a waiting-type floating-point instruction issues |
| fp_exc_pending | input | 1 | An unmasked floating-point exception is pending |
| dna_trap | output | 1 | Device-not-available trap request pulse |
| num_trap | output | 1 | Internal numeric-error trap request pulse |
| trap_vector | output | VEC_W | Vector of the active trap request, 0 when none |
| ext_err | output | 1 | External floating-point error line |

## Verification
The bench targets the priority case. There, a pending exception meets a context that is not the current task's. A design that reported both results would pulse num_trap or raise ext_err together with dna_trap. It also checks that ext_err holds across several idle cycles and drops one cycle after the pending exception clears. A design with a pulsed or sticky line would fail there. Writes of all ones and all zeros expose an extension-type bit that can be cleared and unmodelled bits that keep data. A task switch in the same cycle as a clearing write shows whether the wrong source wins the task-switched flag.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

    // Bit positions in the control register; software decodes these.
    localparam int unsigned BIT_MP = 1;
    localparam int unsigned BIT_TS = 3;
    localparam int unsigned BIT_ET = 4;
    localparam int unsigned BIT_NE = 5;

    // Vector numbers of the two internal traps.
    localparam int unsigned VEC_DNA = 7;
    localparam int unsigned VEC_NUM = 16;

    typedef struct packed {
        logic mon_cop;   // monitor coprocessor
        logic task_sw;   // task switched
        logic num_int;   // numeric exception reported internally
    } fp_flags_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DNA  = 2'd1,
        ACT_NUM  = 2'd2,
        ACT_EXT  = 2'd3
    } fp_action_e;

    // Decide the action for one waiting instruction.
    function automatic fp_action_e pick_action(input fp_flags_t f,
                                               input logic      wait_op,
                                               input logic      pending);
        fp_action_e a;
        a = ACT_NONE;
        if (wait_op) begin
            if (f.mon_cop && f.task_sw)
                a = ACT_DNA;
            else if (pending)
                a = f.num_int ? ACT_NUM : ACT_EXT;
        end
        return a;
    endfunction

endpackage

// File: rtl/fpctl_flag_reg.sv
module fpctl_flag_reg
    import fpctl_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             task_switch,
    output fp_flags_t        flags,
    output logic [REG_W-1:0] rd_data
);

    fp_flags_t flags_q;
    fp_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d.mon_cop = wr_data[BIT_MP];
            flags_d.task_sw = wr_data[BIT_TS];
            flags_d.num_int = wr_data[BIT_NE];
        end
        if (task_switch)
            flags_d.task_sw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;

    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i == BIT_MP) begin : g_mp
            assign rd_data[i] = flags_q.mon_cop;
        end else if (i == BIT_TS) begin : g_ts
            assign rd_data[i] = flags_q.task_sw;
        end else if (i == BIT_ET) begin : g_et
            assign rd_data[i] = 1'b1;
        end else if (i == BIT_NE) begin : g_ne
            assign rd_data[i] = flags_q.num_int;
        end else begin : g_zero
            assign rd_data[i] = 1'b0;
        end
    end

    // R5: a task switch pulse always leaves the flag set
    a_r5_ts_set: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> rd_data[BIT_TS]);

    // R4: a write without task switch lands in the numeric bit
    a_r4_ne_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[BIT_NE] == $past(wr_data[BIT_NE])));

endmodule

// File: rtl/fpctl_trap_gen.sv
module fpctl_trap_gen
    import fpctl_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  fp_flags_t        flags,
    input  logic             wait_op,
    input  logic             pending,
    output fp_action_e       action,
    output logic             dna_req,
    output logic             num_req,
    output logic [VEC_W-1:0] vec
);

    localparam logic [VEC_W-1:0] V_DNA = VEC_W'(VEC_DNA);
    localparam logic [VEC_W-1:0] V_NUM = VEC_W'(VEC_NUM);

    assign action = pick_action(flags, wait_op, pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            dna_req <= 1'b0;
            num_req <= 1'b0;
            vec     <= '0;
        end else begin
            dna_req <= (action == ACT_DNA);
            num_req <= (action == ACT_NUM);
            case (action)
                ACT_DNA: vec <= V_DNA;
                ACT_NUM: vec <= V_NUM;
                default: vec <= '0;
            endcase
        end
    end

    // R12: the two requests never overlap
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dna_req && num_req));

    // R6: a device-not-available request follows a waiting op
    a_r6_dna_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(dna_req) |-> $past(wait_op));

    // R8: a numeric request needs internal reporting and a pending fault
    a_r8_num_cause: assert property (@(posedge clk) disable iff (rst)
        num_req |-> ($past(flags.num_int) && $past(pending)));

    // R10: device-not-available wins over a pending fault
    a_r10_priority: assert property (@(posedge clk) disable iff (rst)
        (wait_op && flags.mon_cop && flags.task_sw) |=> !num_req);

endmodule

// File: rtl/fpctl_err_line.sv
module fpctl_err_line
    import fpctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fp_action_e action,
    input  logic       pending,
    output logic       err_out
);

    always_ff @(posedge clk) begin
        if (rst)
            err_out <= 1'b0;
        else if (!pending)
            err_out <= 1'b0;
        else if (action == ACT_EXT)
            err_out <= 1'b1;
    end

    // R9: the line drops once the pending fault is gone
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        !pending |=> !err_out);

    // R9: the line only rises with an external-report decision
    a_r9_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(err_out) |-> ($past(action) == ACT_EXT));

endmodule

// File: rtl/fpu_fault_ctl.sv
module fpu_fault_ctl
    import fpctl_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cr_wr_en,
    input  logic [REG_W-1:0] cr_wr_data,
    output logic [REG_W-1:0] cr_rd_data,
    input  logic             task_switch,
    input  logic             fp_wait_op,
    input  logic             fp_exc_pending,
    output logic             dna_trap,
    output logic             num_trap,
    output logic [VEC_W-1:0] trap_vector,
    output logic             ext_err
);

    fp_flags_t  flags;
    fp_action_e action;

    fpctl_flag_reg #(.REG_W(REG_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cr_wr_en),
        .wr_data     (cr_wr_data),
        .task_switch (task_switch),
        .flags       (flags),
        .rd_data     (cr_rd_data)
    );

    fpctl_trap_gen #(.VEC_W(VEC_W)) u_trap (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .wait_op (fp_wait_op),
        .pending (fp_exc_pending),
        .action  (action),
        .dna_req (dna_trap),
        .num_req (num_trap),
        .vec     (trap_vector)
    );

    fpctl_err_line u_err (
        .clk     (clk),
        .rst     (rst),
        .action  (action),
        .pending (fp_exc_pending),
        .err_out (ext_err)
    );

    // R12: no vector without a request
    a_r12_idle_vec: assert property (@(posedge clk) disable iff (rst)
        (!dna_trap && !num_trap) |-> (trap_vector == '0));

    // R2: extension type reads set after any write
    a_r2_et_kept: assert property (@(posedge clk) disable iff (rst)
        cr_wr_en |=> cr_rd_data[BIT_ET]);

endmodule

// File: tb/fpu_fault_ctl_tb.sv
module fpu_fault_ctl_tb_top;

    localparam int REG_W = 32;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cr_wr_en = 1'b0;
    logic [REG_W-1:0] cr_wr_data = '0;
    logic [REG_W-1:0] cr_rd_data;
    logic             task_switch = 1'b0;
    logic             fp_wait_op = 1'b0;
    logic             fp_exc_pending = 1'b0;
    logic             dna_trap, num_trap, ext_err;
    logic [VEC_W-1:0] trap_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    fpu_fault_ctl #(.REG_W(REG_W), .VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst(rst), .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data),
        .cr_rd_data(cr_rd_data), .task_switch(task_switch),
        .fp_wait_op(fp_wait_op), .fp_exc_pending(fp_exc_pending),
        .dna_trap(dna_trap), .num_trap(num_trap),
        .trap_vector(trap_vector), .ext_err(ext_err)
    );

    // Behavioural reference model
    int m_mp, m_ts, m_ne, m_dna, m_num, m_err;

    always @(posedge clk) begin
        int hit;
        if (rst) begin
            m_mp = 0; m_ts = 0; m_ne = 0; m_dna = 0; m_num = 0; m_err = 0;
        end else begin
            hit   = (fp_wait_op && m_mp == 1 && m_ts == 1) ? 1 : 0;
            m_dna = hit;
            m_num = (fp_wait_op && hit == 0 && fp_exc_pending && m_ne == 1) ? 1 : 0;
            if (!fp_exc_pending) m_err = 0;
            else if (fp_wait_op && hit == 0 && m_ne == 0) m_err = 1;
            if (cr_wr_en) begin
                m_mp = cr_wr_data[1]; m_ts = cr_wr_data[3]; m_ne = cr_wr_data[5];
            end
            if (task_switch) m_ts = 1;
        end
    end

    function automatic int exp_rd();
        return (m_ne << 5) | 16 | (m_ts << 3) | (m_mp << 1);
    endfunction

    function automatic int exp_vec();
        return m_dna == 1 ? 7 : (m_num == 1 ? 16 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cr_rd_data == REG_W'(exp_rd()), "R4 readback", int'(cr_rd_data), exp_rd());
            chk(dna_trap == m_dna[0], "R6 dna_trap", int'(dna_trap), m_dna);
            chk(num_trap == m_num[0], "R8 num_trap", int'(num_trap), m_num);
            chk(ext_err == m_err[0], "R9 ext_err", int'(ext_err), m_err);
            chk(trap_vector == VEC_W'(exp_vec()), "R12 trap_vector",
                int'(trap_vector), exp_vec());
        end
    end

    // One cycle of stimulus; returns at the negedge after the edge that used it
    task automatic cyc(input bit we, input int data, input bit tsw, input bit wt);
        cr_wr_en    = we;
        cr_wr_data  = REG_W'(data);
        task_switch = tsw;
        fp_wait_op  = wt;
        @(negedge clk);
        cr_wr_en = 0; task_switch = 0; fp_wait_op = 0;
    endtask

    task automatic wr(input int data);
        cyc(1, data, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(cr_rd_data == 32'h10, "R1 reset readback", int'(cr_rd_data), 32'h10);
        chk(!dna_trap && !num_trap && !ext_err && trap_vector == 0, "R1 reset outputs",
            int'({dna_trap, num_trap, ext_err}), 0);

        // R3 / R4: all ones keeps only modelled bits
        wr(32'hFFFF_FFFF);
        chk(cr_rd_data == 32'h3A, "R3 unmodelled bits zero", int'(cr_rd_data), 32'h3A);
        // R2: zero write cannot clear extension type
        wr(0);
        chk(cr_rd_data == 32'h10, "R2 extension type fixed", int'(cr_rd_data), 32'h10);

        // R6: device not available
        wr(32'h0A);
        cyc(0, 0, 0, 1);
        chk(dna_trap && trap_vector == 7, "R6 dna vector 7", int'(trap_vector), 7);
        @(negedge clk);
        chk(!dna_trap && trap_vector == 0, "R12 single pulse", int'(dna_trap), 0);

        // R7: only one of the two flags
        wr(32'h02); cyc(0, 0, 0, 1);
        chk(!dna_trap, "R7 mp only", int'(dna_trap), 0);
        wr(32'h08); cyc(0, 0, 0, 1);
        chk(!dna_trap, "R7 ts only", int'(dna_trap), 0);

        // R8: internal numeric trap
        wr(32'h20);
        fp_exc_pending = 1;
        cyc(0, 0, 0, 1);
        chk(num_trap && trap_vector == 16, "R8 num vector 16", int'(trap_vector), 16);
        chk(!ext_err, "R8 no ext_err", int'(ext_err), 0);
        @(negedge clk);
        chk(!num_trap, "R12 num single pulse", int'(num_trap), 0);

        // R9: external error line
        wr(32'h00);
        cyc(0, 0, 0, 1);
        chk(ext_err && !num_trap, "R9 ext_err raised", int'(ext_err), 1);
        repeat (4) @(negedge clk);
        chk(ext_err, "R9 ext_err held", int'(ext_err), 1);
        fp_exc_pending = 0;
        @(negedge clk);
        chk(!ext_err, "R9 ext_err released", int'(ext_err), 0);

        // R10: priority of device-not-available
        fp_exc_pending = 1;
        wr(32'h2A); cyc(0, 0, 0, 1);
        chk(dna_trap && !num_trap, "R10 dna over num", int'(num_trap), 0);
        wr(32'h0A); cyc(0, 0, 0, 1);
        chk(dna_trap && !ext_err, "R10 dna over ext", int'(ext_err), 0);
        fp_exc_pending = 0;

        // R11: nothing to do
        wr(32'h20); cyc(0, 0, 0, 1);
        chk(!dna_trap && !num_trap && !ext_err, "R11 quiet wait",
            int'({dna_trap, num_trap, ext_err}), 0);

        // R5: task switch beats a clearing write
        cyc(1, 0, 1, 0);
        chk(cr_rd_data == 32'h18, "R5 task switch wins", int'(cr_rd_data), 32'h18);

        // Mixed stream checked by the per-cycle model
        for (int i = 0; i < 3000; i++) begin
            fp_exc_pending = ($urandom_range(0, 3) != 0);
            cyc($urandom_range(0, 5) == 0, $urandom, $urandom_range(0, 9) == 0,
                $urandom_range(0, 1) == 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule